// File: doc/BRIEF.md
# Per-Channel Window Alarm Generator

This block watches the stream of conversion results from a multichannel sampling converter and checks each one against a pair of limits held for its own channel: an upper limit and a lower limit. A result above the upper limit raises the high alarm. A result below the lower limit raises the low alarm. The alarms do not follow the comparison directly. They are timed to the serial frame.

An alarm takes its new value on the twelfth serial-clock falling edge of the frame whose conversion caused it. It is cleared on the tenth falling edge of the following frame. The surrounding logic supplies the frame timing as two single-cycle strobes. One marks the chip-select fall that opens a frame. The other marks each serial-clock falling edge.

A write port loads the limits one at a time. Two general-purpose output pins can each carry the high alarm, the low alarm, both ORed together, or nothing, depending on a per-pin routing code.

Top module: `wa_alarm_gen`

## Requirements
- R1: After reset both alarm outputs and both pin outputs are low. Every upper limit resets to all ones and every lower limit to zero, so no result raises an alarm until the limits are programmed.
- R2: Each channel keeps its own upper and lower limit. A write with `thr_we`=1 loads `thr_val` into the upper limit (`thr_is_high`=1) or the lower limit (`thr_is_high`=0) of channel `thr_ch`, and leaves every other limit unchanged.
- R3: The high alarm is raised only when the result is strictly greater than its channel's upper limit. A result equal to the limit raises nothing.
- R4: The low alarm is raised only when the result is strictly less than its channel's lower limit. A result equal to the limit raises nothing.
- R5: Serial-clock falling edges are numbered from 1 after each `cs_fall` strobe. On the 12th edge strobe, `conv_ch` and `conv_data` are compared, and both alarm outputs take the outcome in the following clock cycle.
- R6: On the 10th edge strobe of a frame, both alarms are cleared, with the outputs low in the following cycle.
- R7: When consecutive frames both violate, the alarm is low from the 10th edge of the second frame until its 12th edge, and is then raised again.
- R8: Each pin has a 2-bit routing code. Bit 0 selects the high alarm and bit 1 selects the low alarm. The pin is the OR of the selected alarms, and code 00 holds it low.
- R9: Edge strobes beyond the 16th edge of a frame, or before the first `cs_fall` after reset, neither set nor clear the alarms.
- R10: Outside the 10th and 12th edge strobes, the alarm outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_fall | input | 1 | One-cycle strobe that opens a frame |
| sclk_fall | input | 1 | One-cycle strobe for each serial-clock falling edge |
| conv_ch | input | CHW | Channel of the conversion in progress |
| conv_data | input | DW | Conversion result |
| thr_we | input | 1 | Limit write enable |
| thr_ch | input | CHW | Channel whose limit is written |
| thr_is_high | input | 1 | 1 selects the upper limit, 0 the lower limit |
| thr_val | input | DW | Limit value to write |
| gpio0_src | input | 2 | Routing code for pin 0 |
| gpio1_src | input | 2 | Routing code for pin 1 |
| alarm_hi | output | 1 | High alarm |
| alarm_lo | output | 1 | Low alarm |
| gpio0_alarm | output | 1 | Pin 0 alarm |
| gpio1_alarm | output | 1 | Pin 1 alarm |

## Verification
The assertions rely on some properties of the inputs:
- `cs_fall` and `sclk_fall` are one-cycle strobes that are never high in the same cycle.
- The routing codes only change while the alarms are not being compared.
- The checker keeps its own count of edges from the strobes, so it assumes the numbering restarts on every `cs_fall`.

The driver keeps to these rules. It raises each strobe for exactly one cycle, with an idle cycle after it. It holds the channel and result steady for the whole frame. It changes routing and limits only between frames.

// File: rtl/wa_pkg.sv
package wa_pkg;

  typedef struct packed {
    logic lo;
    logic hi;
  } wa_flags_t;

  typedef struct packed {
    logic use_lo;
    logic use_hi;
  } wa_route_t;

  function automatic logic wa_route(input wa_route_t sel, input wa_flags_t f);
    return (sel.use_hi & f.hi) | (sel.use_lo & f.lo);
  endfunction

endpackage

// File: rtl/wa_frame_timer.sv
module wa_frame_timer #(
  parameter int FRAME_EDGES = 16,
  parameter int SET_EDGE    = 12,
  parameter int CLR_EDGE    = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_fall,
  input  logic sclk_fall,
  output logic set_stb,
  output logic clr_stb
);
  localparam int CW = $clog2(FRAME_EDGES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          frame_full;

  assign frame_full = (cnt_q == CW'(FRAME_EDGES));
  assign cnt_en     = cs_fall | (sclk_fall & ~frame_full);

  always_comb begin
    cnt_d = cnt_q;
    if (cs_fall)
      cnt_d = '0;
    else if (sclk_fall && !frame_full)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= CW'(FRAME_EDGES);
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign set_stb = sclk_fall & ~cs_fall & (cnt_q == CW'(SET_EDGE - 1));
  assign clr_stb = sclk_fall & ~cs_fall & (cnt_q == CW'(CLR_EDGE - 1));

endmodule

// File: rtl/wa_thresh_bank.sv
module wa_thresh_bank #(
  parameter int NCH = 16,
  parameter int DW  = 12,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [CHW-1:0] wr_ch,
  input  logic           wr_is_high,
  input  logic [DW-1:0]  wr_val,
  input  logic [CHW-1:0] rd_ch,
  output logic [DW-1:0]  rd_hi,
  output logic [DW-1:0]  rd_lo
);
  logic [DW-1:0] hi_q [NCH];
  logic [DW-1:0] lo_q [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel, hi_en, lo_en;
    assign sel   = wr_en & (wr_ch == CHW'(c));
    assign hi_en = sel & wr_is_high;
    assign lo_en = sel & ~wr_is_high;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        hi_q[c] <= '1;
      else if (hi_en)
        hi_q[c] <= wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lo_q[c] <= '0;
      else if (lo_en)
        lo_q[c] <= wr_val;
    end
  end

  always_comb begin
    rd_hi = '1;
    rd_lo = '0;
    for (int c = 0; c < NCH; c++) begin
      if (rd_ch == CHW'(c)) begin
        rd_hi = hi_q[c];
        rd_lo = lo_q[c];
      end
    end
  end

endmodule

// File: rtl/wa_window_cmp.sv
module wa_window_cmp
  import wa_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic [DW-1:0] sample,
  input  logic [DW-1:0] upper,
  input  logic [DW-1:0] lower,
  output wa_flags_t     viol
);
  always_comb begin
    viol.hi = (sample > upper);
    viol.lo = (sample < lower);
  end
endmodule

// File: rtl/wa_alarm_gen.sv
module wa_alarm_gen
  import wa_pkg::*;
#(
  parameter int NCH         = 16,
  parameter int DW          = 12,
  parameter int FRAME_EDGES = 16,
  parameter int SET_EDGE    = 12,
  parameter int CLR_EDGE    = 10,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_fall,
  input  logic           sclk_fall,
  input  logic [CHW-1:0] conv_ch,
  input  logic [DW-1:0]  conv_data,
  input  logic           thr_we,
  input  logic [CHW-1:0] thr_ch,
  input  logic           thr_is_high,
  input  logic [DW-1:0]  thr_val,
  input  logic [1:0]     gpio0_src,
  input  logic [1:0]     gpio1_src,
  output logic           alarm_hi,
  output logic           alarm_lo,
  output logic           gpio0_alarm,
  output logic           gpio1_alarm
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe_q <= 2'b00;
    else
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  logic          set_stb, clr_stb;
  logic [DW-1:0] lim_hi, lim_lo;
  wa_flags_t     viol;
  wa_flags_t     alm_q, alm_d;
  logic          alm_en;

  wa_frame_timer #(
    .FRAME_EDGES(FRAME_EDGES),
    .SET_EDGE   (SET_EDGE),
    .CLR_EDGE   (CLR_EDGE)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .cs_fall  (cs_fall),
    .sclk_fall(sclk_fall),
    .set_stb  (set_stb),
    .clr_stb  (clr_stb)
  );

  wa_thresh_bank #(
    .NCH(NCH),
    .DW (DW)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en     (thr_we),
    .wr_ch     (thr_ch),
    .wr_is_high(thr_is_high),
    .wr_val    (thr_val),
    .rd_ch     (conv_ch),
    .rd_hi     (lim_hi),
    .rd_lo     (lim_lo)
  );

  wa_window_cmp #(
    .DW(DW)
  ) u_cmp (
    .sample(conv_data),
    .upper (lim_hi),
    .lower (lim_lo),
    .viol  (viol)
  );

  assign alm_en = set_stb | clr_stb;

  always_comb begin
    alm_d = alm_q;
    if (set_stb)
      alm_d = viol;
    else if (clr_stb)
      alm_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)
      alm_q <= '0;
    else if (alm_en)
      alm_q <= alm_d;
  end

  assign alarm_hi    = alm_q.hi;
  assign alarm_lo    = alm_q.lo;
  assign gpio0_alarm = wa_route(wa_route_t'(gpio0_src), alm_q);
  assign gpio1_alarm = wa_route(wa_route_t'(gpio1_src), alm_q);

endmodule

// File: rtl/wa_alarm_gen_chk.sv
module wa_alarm_gen_chk #(
  parameter int FRAME_EDGES = 16,
  parameter int SET_EDGE    = 12,
  parameter int CLR_EDGE    = 10
) (
  input logic       clk,
  input logic       rst_n_s,
  input logic       cs_fall,
  input logic       sclk_fall,
  input logic [1:0] gpio0_src,
  input logic [1:0] gpio1_src,
  input logic       alarm_hi,
  input logic       alarm_lo,
  input logic       gpio0_alarm,
  input logic       gpio1_alarm
);
  localparam int CW = $clog2(FRAME_EDGES + 1);

  logic [CW-1:0] edge_q;
  logic          at_set, at_clr;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)
      edge_q <= CW'(FRAME_EDGES);
    else if (cs_fall)
      edge_q <= '0;
    else if (sclk_fall && edge_q != CW'(FRAME_EDGES))
      edge_q <= edge_q + 1'b1;
  end

  assign at_set = sclk_fall && !cs_fall && edge_q == CW'(SET_EDGE - 1);
  assign at_clr = sclk_fall && !cs_fall && edge_q == CW'(CLR_EDGE - 1);

  a_r5_hi_rise_on_set: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(alarm_hi) |-> $past(at_set));
  a_r5_lo_rise_on_set: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(alarm_lo) |-> $past(at_set));
  a_r6_cleared_after_clr: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(at_clr) |-> (!alarm_hi && !alarm_lo));
  a_r10_hold_between: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!$past(at_set) && !$past(at_clr)) |-> $stable({alarm_hi, alarm_lo}));
  a_r8_pin0_follows_hi: assert property (@(posedge clk) disable iff (!rst_n_s)
    (alarm_hi && gpio0_src[0]) |-> gpio0_alarm);
  a_r8_pin1_follows_lo: assert property (@(posedge clk) disable iff (!rst_n_s)
    (alarm_lo && gpio1_src[1]) |-> gpio1_alarm);
  a_r8_pins_idle: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!alarm_hi && !alarm_lo) |-> (!gpio0_alarm && !gpio1_alarm));

endmodule

bind wa_alarm_gen wa_alarm_gen_chk #(
  .FRAME_EDGES(FRAME_EDGES),
  .SET_EDGE   (SET_EDGE),
  .CLR_EDGE   (CLR_EDGE)
) u_chk (
  .clk        (clk),
  .rst_n_s    (rst_n_s),
  .cs_fall    (cs_fall),
  .sclk_fall  (sclk_fall),
  .gpio0_src  (gpio0_src),
  .gpio1_src  (gpio1_src),
  .alarm_hi   (alarm_hi),
  .alarm_lo   (alarm_lo),
  .gpio0_alarm(gpio0_alarm),
  .gpio1_alarm(gpio1_alarm)
);

// File: tb/wa_alarm_gen_bench.sv
module wa_alarm_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;
  localparam int DW  = 12;
  localparam int CHW = 4;

  logic           clk, rst_n, cs_fall, sclk_fall, thr_we, thr_is_high;
  logic [CHW-1:0] conv_ch, thr_ch;
  logic [DW-1:0]  conv_data, thr_val;
  logic [1:0]     gpio0_src, gpio1_src;
  logic           alarm_hi, alarm_lo, gpio0_alarm, gpio1_alarm;

  wa_alarm_gen u_wa_alarm_gen (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .sclk_fall(sclk_fall),
    .conv_ch(conv_ch), .conv_data(conv_data), .thr_we(thr_we), .thr_ch(thr_ch),
    .thr_is_high(thr_is_high), .thr_val(thr_val), .gpio0_src(gpio0_src),
    .gpio1_src(gpio1_src), .alarm_hi(alarm_hi), .alarm_lo(alarm_lo),
    .gpio0_alarm(gpio0_alarm), .gpio1_alarm(gpio1_alarm)
  );

  int n_tests = 0;
  int n_fail  = 0;

  logic [DW-1:0] m_hi [NCH];
  logic [DW-1:0] m_lo [NCH];

  typedef struct {
    logic  hi;
    logic  lo;
    string req;
  } exp_t;
  exp_t sb[$];
  event ev_set;
  logic prev_hi, prev_lo;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  function automatic logic route(input logic [1:0] s, input logic h, input logic l);
    return (s[0] & h) | (s[1] & l);
  endfunction

  // monitor: pops expected items after each 12th edge
  initial begin
    forever begin
      @(ev_set);
      #(CLK_PERIOD/4);
      if (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        chk(it.req, "alarm_hi", alarm_hi, it.hi);
        chk(it.req, "alarm_lo", alarm_lo, it.lo);
        chk("R8", "gpio0_alarm", gpio0_alarm, route(gpio0_src, it.hi, it.lo));
        chk("R8", "gpio1_alarm", gpio1_alarm, route(gpio1_src, it.hi, it.lo));
      end
    end
  end

  task automatic edge_pulse();
    @(negedge clk) sclk_fall = 1'b1;
    @(negedge clk) sclk_fall = 1'b0;
  endtask

  task automatic wr(input int ch, input logic is_hi, input logic [DW-1:0] v);
    @(negedge clk);
    thr_we = 1'b1; thr_ch = CHW'(ch); thr_is_high = is_hi; thr_val = v;
    @(negedge clk) thr_we = 1'b0;
    if (is_hi) m_hi[ch] = v; else m_lo[ch] = v;
  endtask

  task automatic run_frame(input int ch, input logic [DW-1:0] d, input string req);
    exp_t it;
    @(negedge clk);
    cs_fall = 1'b1; conv_ch = CHW'(ch); conv_data = d;
    @(negedge clk) cs_fall = 1'b0;
    for (int e = 1; e <= 16; e++) begin
      edge_pulse();
      if (e == 9) begin
        chk("R10", "hi held to edge 9", alarm_hi, prev_hi);
        chk("R10", "lo held to edge 9", alarm_lo, prev_lo);
      end
      if (e == 10) begin
        chk("R6", "hi clear at edge 10", alarm_hi, 1'b0);
        chk("R6", "lo clear at edge 10", alarm_lo, 1'b0);
      end
      if (e == 11 && prev_hi) chk("R7", "hi low at edge 11", alarm_hi, 1'b0);
      if (e == 12) begin
        it.hi  = d > m_hi[ch];
        it.lo  = d < m_lo[ch];
        it.req = req;
        prev_hi = it.hi;
        prev_lo = it.lo;
        sb.push_back(it);
        -> ev_set;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_fall = 1'b0; sclk_fall = 1'b0; thr_we = 1'b0; thr_is_high = 1'b0;
    conv_ch = '0; thr_ch = '0; conv_data = '0; thr_val = '0;
    gpio0_src = 2'b01; gpio1_src = 2'b10;
    prev_hi = 1'b0; prev_lo = 1'b0;
    for (int c = 0; c < NCH; c++) begin m_hi[c] = '1; m_lo[c] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    chk("R1", "alarm_hi after reset", alarm_hi, 1'b0);
    chk("R1", "alarm_lo after reset", alarm_lo, 1'b0);
    chk("R1", "gpio0 after reset", gpio0_alarm, 1'b0);
    chk("R1", "gpio1 after reset", gpio1_alarm, 1'b0);

    // R9: edges before any frame has opened do nothing
    for (int i = 0; i < 14; i++) edge_pulse();
    chk("R9", "hi after stray edges", alarm_hi, 1'b0);

    run_frame(0, 12'hFFF, "R1");
    run_frame(0, 12'h000, "R1");

    wr(3, 1'b1, 12'd2000);
    wr(3, 1'b0, 12'd500);
    run_frame(3, 12'd2001, "R3");
    run_frame(3, 12'd2000, "R3");
    run_frame(3, 12'd499, "R4");
    run_frame(3, 12'd500, "R4");
    run_frame(5, 12'd2001, "R2");
    run_frame(5, 12'd100, "R2");

    // R7: back-to-back violations
    run_frame(3, 12'd3000, "R7");
    run_frame(3, 12'd3000, "R7");

    // R9: surplus edges after the 16th keep the alarm
    for (int i = 0; i < 20; i++) edge_pulse();
    chk("R9", "hi kept after surplus edges", alarm_hi, 1'b1);

    // R8 routing variants
    gpio0_src = 2'b11; gpio1_src = 2'b00;
    run_frame(3, 12'd10, "R8");
    chk("R8", "pin0 combined low alarm", gpio0_alarm, 1'b1);
    chk("R8", "pin1 code 00", gpio1_alarm, 1'b0);
    gpio0_src = 2'b10; gpio1_src = 2'b01;
    run_frame(3, 12'd4000, "R8");
    chk("R8", "pin0 low-only with high alarm", gpio0_alarm, 1'b0);
    chk("R8", "pin1 high-only with high alarm", gpio1_alarm, 1'b1);

    // R2: write other channel, ch3 unchanged
    wr(7, 1'b1, 12'd50);
    run_frame(7, 12'd51, "R2");
    run_frame(3, 12'd51, "R2");
    run_frame(3, 12'd1000, "R6");

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule